// File: doc/BRIEF.md
# Local Configuration Header Access Port

This block lets the local processor read and modify the bridge's own configuration header through three words on the local register bus, with no cycle ever reaching the external bus. Software first writes a command word. That word carries the dword index of a configuration register, a direction flag and four active-low byte-lane enables. For a read, the port fetches the whole addressed dword into a read-data holding register. Software then fetches that register and extracts the lanes it needs. For a write, nothing changes until software writes the write-data word. That data write updates only the lanes enabled in the latched command.

Behind the port sits a small configuration array:
- a combined command/status word, whose received-abort flags are set by hardware event pulses and cleared by writing one;
- six base-address registers;
- a timeout word that holds a retry limit and a ready limit.

Every other configuration offset reads as zero and ignores writes.

Top module: `cfgp_port`

## Requirements
- R1: After reset, the command word reads 0 and the read-data word reads 0. Every base-address register and the command/status word read 0. The timeout word reads 0x000080FF.
- R2: Bus offset 0x10 is the command word. Bits [7:2] give the dword index and bits [1:0] are ignored. Bit 16 set means write and bit 16 clear means read. Bits [23:20] are active-low lane enables, where bit 20+n gates byte lane n (data bits [8n+7:8n]). A bus read of 0x10 returns the latched fields with every other bit zero.
- R3: Writing a read command to 0x10 loads the full dword at that index into the read-data word at bus offset 0x18. The new value is readable from the second cycle after the command write.
- R4: The configuration array changes only when bus offset 0x14 is written while the latched command has its write flag set. A command write alone changes nothing. A data write under a read command changes nothing.
- R5: A committed write updates exactly the byte lanes whose enable bit is 0. All other lanes keep their value.
- R6: Configuration byte offsets 0x10, 0x14, 0x18, 0x1C, 0x20 and 0x24 (dword indices 4 to 9) are six fully writable 32-bit base-address registers.
- R7: Offset 0x04 (index 1) is command/status. Bits [15:0] are read/write. Bit 29 (master abort received) is set by a pulse on `mabort_i`. Bit 28 (target abort received) is set by a pulse on `tabort_i`. Each flag clears only when a committed write with lane 3 enabled has a one in that bit. A set pulse in the same cycle as a clear wins. All other bits read 0.
- R8: Offset 0x40 (index 16) holds the retry limit in bits [15:8] (reset 0x80) and the ready limit in bits [7:0] (reset 0xFF). Bits [31:16] read 0 and ignore writes.
- R9: Every other configuration index reads 0, and writes to it have no effect.
- R10: A bus read raises `bus_rvalid_o` for exactly the next cycle, with the data on `bus_rdata_o` at the same time. Offset 0x14 and every unmapped bus offset read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_i | input | 1 | Register bus write strobe |
| bus_rd_i | input | 1 | Register bus read strobe |
| bus_addr_i | input | BUS_AW | Register bus byte offset |
| bus_wdata_i | input | 32 | Register bus write data |
| bus_rdata_o | output | 32 | Registered read data |
| bus_rvalid_o | output | 1 | Read data valid, one cycle after a read strobe |
| mabort_i | input | 1 | Pulse: master abort received |
| tabort_i | input | 1 | Pulse: target abort received |

## Verification
The bench targets lane masking with sparse enable patterns. A design that inverts the active-low sense, or shifts the lanes, corrupts the untouched bytes of a base-address register. It tries a command write with no data write, and a data write under a read command. A design that commits on the command word, or ignores the direction flag, would alter the array in these cases. It drives an abort pulse in the same cycle as a write-one-to-clear. It also clears with lane 3 disabled, and writes to the read-only upper timeout bits and to unimplemented offsets. A wrong priority, a missing lane gate or a missing read-only mask each show up as a nonzero or stale read-back. Random command/data sequences are compared against a bench model of the whole configuration array.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
  localparam int unsigned DW    = 32;
  localparam int unsigned LANES = DW / 8;

  // Local register bus offsets
  localparam logic [7:0] OFS_CMD   = 8'h10;
  localparam logic [7:0] OFS_WDATA = 8'h14;
  localparam logic [7:0] OFS_RDATA = 8'h18;

  // Command word fields
  localparam int unsigned CMD_WR_BIT = 16;
  localparam int unsigned CMD_BE_LSB = 20;

  // Status flags inside the command/status dword
  localparam int unsigned STAT_TABT_BIT = 28;
  localparam int unsigned STAT_MABT_BIT = 29;
  localparam int unsigned STAT_LANE     = STAT_MABT_BIT / 8;
endpackage

// File: rtl/cfgp_cmd_decode.sv
module cfgp_cmd_decode
  import cfgp_pkg::*;
#(
  parameter int unsigned BUS_AW = 8,
  parameter int unsigned IDX_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr_i,
  input  logic [BUS_AW-1:0] bus_addr_i,
  input  logic [IDX_W-1:0]  cmd_idx_i,
  input  logic              cmd_wr_i,
  input  logic [LANES-1:0]  cmd_be_n_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic              wr_flag_o,
  output logic [LANES-1:0]  lane_en_o,
  output logic [DW-1:0]     cmd_word_o,
  output logic              commit_o,
  output logic              rd_pend_o
);
  logic [IDX_W-1:0] idx_q;
  logic             wr_q;
  logic [LANES-1:0] be_n_q;
  logic             rd_pend_q;
  logic             cmd_we;
  logic             data_we;

  assign cmd_we  = bus_wr_i && (bus_addr_i == BUS_AW'(OFS_CMD));
  assign data_we = bus_wr_i && (bus_addr_i == BUS_AW'(OFS_WDATA));

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q     <= '0;
      wr_q      <= 1'b0;
      be_n_q    <= '0;
      rd_pend_q <= 1'b0;
    end else begin
      rd_pend_q <= 1'b0;
      if (cmd_we) begin
        idx_q     <= cmd_idx_i;
        wr_q      <= cmd_wr_i;
        be_n_q    <= cmd_be_n_i;
        rd_pend_q <= !cmd_wr_i;
      end
    end
  end

  always_comb begin
    cmd_word_o                       = '0;
    cmd_word_o[IDX_W+1:2]            = idx_q;
    cmd_word_o[CMD_WR_BIT]           = wr_q;
    cmd_word_o[CMD_BE_LSB +: LANES]  = be_n_q;
  end

  assign idx_o     = idx_q;
  assign wr_flag_o = wr_q;
  assign lane_en_o = ~be_n_q;
  assign commit_o  = data_we && wr_q;
  assign rd_pend_o = rd_pend_q;
endmodule

// File: rtl/cfgp_bar_bank.sv
module cfgp_bar_bank
  import cfgp_pkg::*;
#(
  parameter int unsigned IDX_W    = 6,
  parameter int unsigned NUM_BARS = 6,
  parameter int unsigned BASE_IDX = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             commit_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [LANES-1:0] lane_en_i,
  input  logic [DW-1:0]    wdata_i,
  output logic             hit_o,
  output logic [DW-1:0]    rd_word_o
);
  logic [NUM_BARS-1:0] hits;
  logic [DW-1:0]       slice [NUM_BARS];

  for (genvar b = 0; b < NUM_BARS; b++) begin : g_bar
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(BASE_IDX + b);
    logic [DW-1:0] q;

    always_ff @(posedge clk) begin
      if (rst) begin
        q <= '0;
      end else if (commit_i && (idx_i == MY_IDX)) begin
        for (int l = 0; l < LANES; l++) begin
          if (lane_en_i[l]) q[8*l +: 8] <= wdata_i[8*l +: 8];
        end
      end
    end

    assign hits[b]  = (idx_i == MY_IDX);
    assign slice[b] = hits[b] ? q : '0;
  end

  always_comb begin
    rd_word_o = '0;
    for (int b = 0; b < NUM_BARS; b++) rd_word_o = rd_word_o | slice[b];
  end

  assign hit_o = |hits;
endmodule

// File: rtl/cfgp_ctrl_regs.sv
module cfgp_ctrl_regs
  import cfgp_pkg::*;
#(
  parameter int unsigned IDX_W       = 6,
  parameter int unsigned CMDSTAT_IDX = 1,
  parameter int unsigned TMO_IDX     = 16,
  parameter logic [7:0]  RETRY_RST   = 8'h80,
  parameter logic [7:0]  READY_RST   = 8'hFF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             commit_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [1:0]       en_lo_i,
  input  logic             en_stat_i,
  input  logic [15:0]      wdata_lo_i,
  input  logic             wdata_mabt_i,
  input  logic             wdata_tabt_i,
  input  logic             mabort_i,
  input  logic             tabort_i,
  output logic [DW-1:0]    cs_word_o,
  output logic [DW-1:0]    tmo_word_o,
  output logic             stat_mabt_o
);
  logic [15:0] cmd_q;
  logic        mabt_q;
  logic        tabt_q;
  logic [7:0]  retry_q;
  logic [7:0]  ready_q;
  logic        hit_cs;
  logic        hit_tmo;
  logic        clr_mabt;
  logic        clr_tabt;

  assign hit_cs   = commit_i && (idx_i == IDX_W'(CMDSTAT_IDX));
  assign hit_tmo  = commit_i && (idx_i == IDX_W'(TMO_IDX));
  assign clr_mabt = hit_cs && en_stat_i && wdata_mabt_i;
  assign clr_tabt = hit_cs && en_stat_i && wdata_tabt_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q   <= '0;
      mabt_q  <= 1'b0;
      tabt_q  <= 1'b0;
      retry_q <= RETRY_RST;
      ready_q <= READY_RST;
    end else begin
      if (hit_cs && en_lo_i[0])  cmd_q[7:0]  <= wdata_lo_i[7:0];
      if (hit_cs && en_lo_i[1])  cmd_q[15:8] <= wdata_lo_i[15:8];
      if (hit_tmo && en_lo_i[0]) ready_q     <= wdata_lo_i[7:0];
      if (hit_tmo && en_lo_i[1]) retry_q     <= wdata_lo_i[15:8];
      // a new event outranks a clear in the same cycle
      mabt_q <= mabort_i || (mabt_q && !clr_mabt);
      tabt_q <= tabort_i || (tabt_q && !clr_tabt);
    end
  end

  always_comb begin
    cs_word_o                = '0;
    cs_word_o[15:0]          = cmd_q;
    cs_word_o[STAT_MABT_BIT] = mabt_q;
    cs_word_o[STAT_TABT_BIT] = tabt_q;
    tmo_word_o               = '0;
    tmo_word_o[15:8]         = retry_q;
    tmo_word_o[7:0]          = ready_q;
  end

  assign stat_mabt_o = mabt_q;
endmodule

// File: rtl/cfgp_port.sv
module cfgp_port
  import cfgp_pkg::*;
#(
  parameter int unsigned BUS_AW       = 8,
  parameter int unsigned CFG_AW       = 8,
  parameter int unsigned NUM_BARS     = 6,
  parameter int unsigned BAR_BASE_IDX = 4,
  parameter int unsigned CMDSTAT_IDX  = 1,
  parameter int unsigned TMO_IDX      = 16,
  parameter logic [7:0]  RETRY_RST    = 8'h80,
  parameter logic [7:0]  READY_RST    = 8'hFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [BUS_AW-1:0] bus_addr_i,
  input  logic [DW-1:0]     bus_wdata_i,
  output logic [DW-1:0]     bus_rdata_o,
  output logic              bus_rvalid_o,
  input  logic              mabort_i,
  input  logic              tabort_i
);
  localparam int unsigned IDX_W = CFG_AW - 2;

  logic [IDX_W-1:0] idx;
  logic             wr_flag;
  logic [LANES-1:0] lane_en;
  logic [DW-1:0]    cmd_word;
  logic             commit;
  logic             rd_pend;
  logic             bar_hit;
  logic [DW-1:0]    bar_word;
  logic [DW-1:0]    cs_word;
  logic [DW-1:0]    tmo_word;
  logic             stat_mabt;
  logic [DW-1:0]    cfg_rd_word;
  logic [DW-1:0]    rdata_q;

  cfgp_cmd_decode #(.BUS_AW(BUS_AW), .IDX_W(IDX_W)) u_dec (
    .clk        (clk),
    .rst        (rst),
    .bus_wr_i   (bus_wr_i),
    .bus_addr_i (bus_addr_i),
    .cmd_idx_i  (bus_wdata_i[IDX_W+1:2]),
    .cmd_wr_i   (bus_wdata_i[CMD_WR_BIT]),
    .cmd_be_n_i (bus_wdata_i[CMD_BE_LSB +: LANES]),
    .idx_o      (idx),
    .wr_flag_o  (wr_flag),
    .lane_en_o  (lane_en),
    .cmd_word_o (cmd_word),
    .commit_o   (commit),
    .rd_pend_o  (rd_pend)
  );

  cfgp_bar_bank #(.IDX_W(IDX_W), .NUM_BARS(NUM_BARS), .BASE_IDX(BAR_BASE_IDX)) u_bars (
    .clk       (clk),
    .rst       (rst),
    .commit_i  (commit),
    .idx_i     (idx),
    .lane_en_i (lane_en),
    .wdata_i   (bus_wdata_i),
    .hit_o     (bar_hit),
    .rd_word_o (bar_word)
  );

  cfgp_ctrl_regs #(
    .IDX_W(IDX_W), .CMDSTAT_IDX(CMDSTAT_IDX), .TMO_IDX(TMO_IDX),
    .RETRY_RST(RETRY_RST), .READY_RST(READY_RST)
  ) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .commit_i     (commit),
    .idx_i        (idx),
    .en_lo_i      (lane_en[1:0]),
    .en_stat_i    (lane_en[STAT_LANE]),
    .wdata_lo_i   (bus_wdata_i[15:0]),
    .wdata_mabt_i (bus_wdata_i[STAT_MABT_BIT]),
    .wdata_tabt_i (bus_wdata_i[STAT_TABT_BIT]),
    .mabort_i     (mabort_i),
    .tabort_i     (tabort_i),
    .cs_word_o    (cs_word),
    .tmo_word_o   (tmo_word),
    .stat_mabt_o  (stat_mabt)
  );

  always_comb begin
    if (bar_hit)                             cfg_rd_word = bar_word;
    else if (idx == IDX_W'(CMDSTAT_IDX))     cfg_rd_word = cs_word;
    else if (idx == IDX_W'(TMO_IDX))         cfg_rd_word = tmo_word;
    else                                     cfg_rd_word = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q      <= '0;
      bus_rdata_o  <= '0;
      bus_rvalid_o <= 1'b0;
    end else begin
      if (rd_pend) rdata_q <= cfg_rd_word;
      bus_rvalid_o <= bus_rd_i;
      if (bus_rd_i) begin
        if (bus_addr_i == BUS_AW'(OFS_CMD))        bus_rdata_o <= cmd_word;
        else if (bus_addr_i == BUS_AW'(OFS_RDATA)) bus_rdata_o <= rdata_q;
        else                                       bus_rdata_o <= '0;
      end
    end
  end
endmodule

// File: rtl/cfgp_port_chk.sv
module cfgp_port_chk
  import cfgp_pkg::*;
#(
  parameter int unsigned BUS_AW      = 8,
  parameter int unsigned IDX_W       = 6,
  parameter int unsigned CMDSTAT_IDX = 1
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr_i,
  input logic              bus_rd_i,
  input logic [BUS_AW-1:0] bus_addr_i,
  input logic [DW-1:0]     bus_rdata_o,
  input logic              bus_rvalid_o,
  input logic              mabort_i,
  input logic              commit,
  input logic              wr_flag,
  input logic [IDX_W-1:0]  idx,
  input logic              stat_lane_en,
  input logic              wdata_mabt,
  input logic              stat_mabt,
  input logic [DW-1:0]     tmo_word
);
  p_rvalid_r10: assert property (@(posedge clk) disable iff (rst)
    bus_rd_i |=> bus_rvalid_o);
  p_no_rvalid_r10: assert property (@(posedge clk) disable iff (rst)
    !bus_rd_i |=> !bus_rvalid_o);
  p_wdata_reads_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (bus_rd_i && bus_addr_i == BUS_AW'(OFS_WDATA)) |=> (bus_rdata_o == '0));
  p_commit_needs_wr_r4: assert property (@(posedge clk) disable iff (rst)
    commit |-> wr_flag);
  p_commit_needs_data_r4: assert property (@(posedge clk) disable iff (rst)
    commit |-> (bus_wr_i && bus_addr_i == BUS_AW'(OFS_WDATA)));
  p_mabort_sets_r7: assert property (@(posedge clk) disable iff (rst)
    mabort_i |=> stat_mabt);
  p_mabt_holds_r7: assert property (@(posedge clk) disable iff (rst)
    (stat_mabt && !(commit && idx == IDX_W'(CMDSTAT_IDX) && stat_lane_en && wdata_mabt))
    |=> stat_mabt);
  p_tmo_stable_r8: assert property (@(posedge clk) disable iff (rst)
    !commit |=> $stable(tmo_word));
endmodule

bind cfgp_port cfgp_port_chk #(
  .BUS_AW(BUS_AW), .IDX_W(IDX_W), .CMDSTAT_IDX(CMDSTAT_IDX)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .bus_wr_i     (bus_wr_i),
  .bus_rd_i     (bus_rd_i),
  .bus_addr_i   (bus_addr_i),
  .bus_rdata_o  (bus_rdata_o),
  .bus_rvalid_o (bus_rvalid_o),
  .mabort_i     (mabort_i),
  .commit       (commit),
  .wr_flag      (wr_flag),
  .idx          (idx),
  .stat_lane_en (lane_en[cfgp_pkg::STAT_LANE]),
  .wdata_mabt   (bus_wdata_i[cfgp_pkg::STAT_MABT_BIT]),
  .stat_mabt    (stat_mabt),
  .tmo_word     (tmo_word)
);

// File: tb/cfgp_port_tb.sv
`timescale 1ns/1ps
module cfgp_port_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic        mabort = 1'b0;
  logic        tabort = 1'b0;

  int n_cmp = 0;
  int n_err = 0;
  bit done = 1'b0;
  logic [31:0] exp_cfg [64];

  always #2.5 clk = ~clk;

  cfgp_port u_dut (
    .clk(clk), .rst(rst), .bus_wr_i(bus_wr), .bus_rd_i(bus_rd),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .bus_rvalid_o(bus_rvalid), .mabort_i(mabort), .tabort_i(tabort)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] lanes(logic [3:0] be_n);
    logic [31:0] m = '0;
    for (int l = 0; l < 4; l++) if (!be_n[l]) m[8*l +: 8] = 8'hFF;
    return m;
  endfunction

  function automatic logic [31:0] cmd_word(int idx, bit wr, logic [3:0] be_n, logic [1:0] junk);
    logic [31:0] w = '0;
    w[7:2] = idx[5:0]; w[1:0] = junk; w[16] = wr; w[23:20] = be_n;
    return w;
  endfunction

  function automatic void model_write(int idx, logic [3:0] be_n, logic [31:0] d);
    logic [31:0] m = lanes(be_n);
    logic [31:0] wm;
    if (idx == 1) begin
      wm = m & 32'h0000FFFF;
      exp_cfg[idx] = (exp_cfg[idx] & ~wm) | (d & wm);
      exp_cfg[idx] = exp_cfg[idx] & ~(d & m & 32'h3000_0000);
    end else if (idx >= 4 && idx <= 9) begin
      exp_cfg[idx] = (exp_cfg[idx] & ~m) | (d & m);
    end else if (idx == 16) begin
      wm = m & 32'h0000FFFF;
      exp_cfg[idx] = (exp_cfg[idx] & ~wm) | (d & wm);
    end
  endfunction

  task automatic bus_write(logic [7:0] a, logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic bus_read(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); d = bus_rdata;
    check("R10 rvalid", {31'd0, bus_rvalid}, 32'd1);
    bus_rd = 1'b0;
  endtask

  task automatic cfg_write(int idx, logic [3:0] be_n, logic [31:0] d);
    bus_write(8'h10, cmd_word(idx, 1'b1, be_n, 2'($urandom)));
    bus_write(8'h14, d);
    model_write(idx, be_n, d);
  endtask

  task automatic cfg_read(int idx, output logic [31:0] d);
    bus_write(8'h10, cmd_word(idx, 1'b0, 4'h0, 2'($urandom)));
    @(negedge clk);
    bus_read(8'h18, d);
  endtask

  task automatic pulse(bit m, bit t);
    @(negedge clk); mabort = m; tabort = t;
    @(negedge clk); mabort = 1'b0; tabort = 1'b0;
    if (m) exp_cfg[1][29] = 1'b1;
    if (t) exp_cfg[1][28] = 1'b1;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_err++;
      $display("FAIL watchdog expired actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd2718));
    for (int i = 0; i < 64; i++) exp_cfg[i] = '0;
    exp_cfg[16] = 32'h0000_80FF;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    bus_read(8'h18, d); check("R1 rdata reset", d, 32'h0);
    bus_read(8'h10, d); check("R1 cmd reset", d, 32'h0);
    cfg_read(16, d);    check("R1 R8 timeout reset", d, 32'h0000_80FF);
    cfg_read(1, d);     check("R1 cmdstat reset", d, 32'h0);
    cfg_read(4, d);     check("R1 bar0 reset", d, 32'h0);

    // R2: field layout, low address bits ignored
    bus_write(8'h10, cmd_word(5, 1'b1, 4'b0110, 2'b11) | 32'hFF0E_FF00);
    bus_read(8'h10, d); check("R2 cmd readback", d, 32'h0061_0014);

    // R4: command alone commits nothing; data under read command ignored
    bus_write(8'h10, cmd_word(4, 1'b1, 4'h0, 2'b00));
    cfg_read(4, d); check("R4 cmd-only no commit", d, 32'h0);
    bus_write(8'h10, cmd_word(4, 1'b0, 4'h0, 2'b00));
    bus_write(8'h14, 32'hDEAD_BEEF);
    cfg_read(4, d); check("R4 data under read ignored", d, 32'h0);

    // R5: lane masking
    cfg_write(5, 4'h0, 32'h1122_3344);
    cfg_write(5, 4'b1010, 32'hAABB_CCDD);
    cfg_read(5, d); check("R5 sparse lanes", d, 32'h11BB_33DD);
    cfg_write(5, 4'hF, 32'h0000_0000);
    cfg_read(5, d); check("R5 no lanes", d, 32'h11BB_33DD);

    // R7: abort flags
    pulse(1'b1, 1'b0);
    pulse(1'b0, 1'b1);
    cfg_read(1, d); check("R7 flags set", d, 32'h3000_0000);
    cfg_write(1, 4'b1000, 32'h3000_ABCD);
    cfg_read(1, d); check("R7 clear blocked lane3 off", d, 32'h3000_ABCD);
    cfg_write(1, 4'b0111, 32'h1000_0000);
    cfg_read(1, d); check("R7 w1c target abort", d, 32'h2000_ABCD);
    bus_write(8'h10, cmd_word(1, 1'b1, 4'b0111, 2'b00));
    @(negedge clk); bus_wr = 1'b1; bus_addr = 8'h14; bus_wdata = 32'h2000_0000; mabort = 1'b1;
    @(negedge clk); bus_wr = 1'b0; mabort = 1'b0;
    cfg_read(1, d); check("R7 set wins over clear", d, 32'h2000_ABCD);

    // R8: upper timeout bits read-only
    cfg_write(16, 4'h0, 32'hFFFF_1234);
    cfg_read(16, d); check("R8 timeout write", d, 32'h0000_1234);

    // R9: unimplemented offsets
    cfg_write(2, 4'h0, 32'hFFFF_FFFF);
    cfg_read(2, d);  check("R9 idx2 zero", d, 32'h0);
    cfg_write(63, 4'h0, 32'h5555_AAAA);
    cfg_read(63, d); check("R9 idx63 zero", d, 32'h0);

    // R10: unmapped bus offsets
    bus_read(8'h14, d); check("R10 wdata reads zero", d, 32'h0);
    bus_read(8'h1C, d); check("R10 unmapped zero", d, 32'h0);

    // R3 R6: random accesses against the model
    for (int it = 0; it < 250; it++) begin
      int r = int'($urandom % 10);
      int idx;
      if (r == 0) idx = 1;
      else if (r <= 6) idx = 3 + r;
      else if (r == 7) idx = 16;
      else if (r == 8) idx = int'($urandom % 64);
      else idx = 4 + int'($urandom % 6);
      if ($urandom % 4 != 0) cfg_write(idx, 4'($urandom), $urandom);
      if ($urandom % 8 == 0) pulse(1'($urandom), 1'($urandom));
      cfg_read(idx, d);
      check($sformatf("R3 R6 random idx %0d", idx), d, exp_cfg[idx]);
    end

    done = 1'b1;
    finish_run();
  end
endmodule